// File: doc/BRIEF.md
# Buffered Serial Transmitter with Fill-Level Interrupt

This block is the sending half of an asynchronous serial port. A host pushes bytes through a simple write strobe into a byte queue of up to 64 entries. A shift stage takes bytes from the queue and sends each one on a single line as a ten-bit character: one low start bit, eight data bits with the least significant bit first, and one high stop bit. When nothing is being sent, the line rests high. Bit timing comes from an external clock-enable pulse that runs at 8 or 16 times the baud rate. A mode input selects whether one bit lasts 8 or 16 of these pulses.

Two status outputs report the two storage stages on their own. The holding flag shows that the queue is empty. The shifter flag shows that the line has finished its last stop bit. A transmit-empty event is latched when the queue's fill level drops under a programmable trigger. The interrupt line carries that event only while it is enabled, and a status read or an accepted write clears it. With queueing switched off, the block behaves as a one-byte holding register. The event then fires each time that register hands its byte to the shifter.

Top module: `serial_tx_engine`

## Requirements
- R1: With queueing on, the queue accepts up to 64 bytes, and a write while 64 bytes are stored is dropped. Bytes leave in the order they were written.
- R2: With queueing off, the holding stage stores at most one byte, and a write while it is full is dropped. The event is latched when the stage empties, and the trigger input has no effect.
- R3: `hold_empty` is 1 exactly when the queue holds no byte. It drops in the cycle after a write is accepted.
- R4: `shift_empty` is 0 from the load of a byte until the end of the last stop bit. While it is 1, `txd` is 1.
- R5: Each character on `txd` is a 0 start bit, then data bits 0 through 7, then a 1 stop bit.
- R6: One bit lasts 16 `tick` pulses when `os8_sel`=0 and 8 pulses when `os8_sel`=1.
- R7: When the shifter is idle, a waiting byte is loaded on the next `tick`. When a byte waits at the end of a stop bit, the next start bit begins immediately, with no idle time between characters.
- R8: With queueing on, `txe_pend` is set in the cycle after the fill level moves from at least `trig_lvl` to below it. A trigger of 0 never sets it. Once cleared, it can be set again by a new crossing.
- R9: `irq` is 1 only while `txe_pend` and `irq_en` are both 1. Setting `irq_en` while an event is pending raises `irq` at once.
- R10: A pulse on `isr_rd`, or an accepted write, clears `txe_pend` in the next cycle unless a new event is set in the same cycle.
- R11: During and after reset, `txd`=1, both empty flags are 1, `txe_pend`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling clock enable, one cycle wide |
| os8_sel | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| fifo_on | input | 1 | 1: 64-byte queue, 0: single holding byte |
| trig_lvl | input | 7 | Fill level under which the transmit-empty event is latched |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to queue |
| isr_rd | input | 1 | Interrupt status read strobe, clears the pending event |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Queue or holding register is empty |
| shift_empty | output | 1 | Shifter has finished its last stop bit |
| txe_pend | output | 1 | Latched transmit-empty event |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
A table of bursts varies the tick rate, the trigger level and the burst length. A burst that stays above the trigger must yield exactly one event, a burst that never reaches the trigger must yield none, and a trigger of zero must also yield none. Every burst is decoded from the line at the bit period its mode implies. A wrong tick count per bit therefore shows up as a framing or data error, and a gap between characters shows up as a missing join. Directed cases cover the following:
- Writing 70 bytes into a busy queue, to expose the exact capacity.
- Two quick writes with queueing off, to show the single-byte limit and the event on each handover.
- Enabling the interrupt only after the event, and clearing it by a read and then by a write, to separate the pending latch from its gate.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic {SH_IDLE, SH_SEND} sh_state_e;

  // Number of oversampling ticks that make up one bit on the line.
  function automatic logic [4:0] ticks_per_bit(input logic os8);
    return os8 ? 5'd8 : 5'd16;
  endfunction

  // Holding capacity for the selected mode.
  function automatic int unsigned hold_cap(input logic fifo_on, input int unsigned depth);
    return fifo_on ? depth : 1;
  endfunction

  // Level condition behind the transmit-empty event.
  function automatic logic below_trig(input int unsigned lvl, input int unsigned trig,
                                      input logic fifo_on);
    if (fifo_on) return lvl < trig;
    return lvl == 0;
  endfunction

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_on,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] level,
  output logic          accept
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cap;

  assign cap    = CW'(txq_pkg::hold_cap(fifo_on, DEPTH));
  assign accept = push && (level < cap);
  assign dout   = mem[rptr];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (accept) wptr <= ptr_next(wptr);
      if (pop)    rptr <= ptr_next(rptr);
      level <= level + CW'(accept) - CW'(pop);
    end
  end
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          os8,
  input  logic          have_data,
  input  logic [DW-1:0] din,
  output logic          pop,
  output logic          txd,
  output logic          idle,
  output logic          frame_done
);
  import txq_pkg::*;

  localparam int FW = DW + 2;
  localparam int BW = $clog2(FW);

  sh_state_e     state;
  logic [FW-1:0] shreg;
  logic [BW-1:0] bidx;
  logic [4:0]    tcnt;
  logic [4:0]    tpb;
  logic          bit_end;

  assign tpb        = ticks_per_bit(os8);
  assign bit_end    = (state == SH_SEND) && tick && (tcnt == tpb - 5'd1);
  assign frame_done = bit_end && (bidx == BW'(FW - 1));
  assign pop        = tick && have_data && ((state == SH_IDLE) || frame_done);
  assign idle       = (state == SH_IDLE);
  assign txd        = idle ? 1'b1 : shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SH_IDLE;
      shreg <= '1;
      bidx  <= '0;
      tcnt  <= '0;
    end else if (pop) begin
      state <= SH_SEND;
      shreg <= {1'b1, din, 1'b0};
      bidx  <= '0;
      tcnt  <= '0;
    end else if (frame_done) begin
      state <= SH_IDLE;
      shreg <= '1;
      tcnt  <= '0;
    end else if (bit_end) begin
      shreg <= {1'b1, shreg[FW-1:1]};
      bidx  <= bidx + 1'b1;
      tcnt  <= '0;
    end else if ((state == SH_SEND) && tick) begin
      tcnt <= tcnt + 5'd1;
    end
  end
endmodule

// File: rtl/txq_irq.sv
module txq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic below,
  input  logic isr_rd,
  input  logic wr_acc,
  input  logic irq_en,
  output logic pend,
  output logic pend_set,
  output logic irq
);
  logic below_q;

  assign pend_set = below && !below_q;
  assign irq      = pend && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      below_q <= 1'b1;
      pend    <= 1'b0;
    end else begin
      below_q <= below;
      if (pend_set)              pend <= 1'b1;
      else if (isr_rd || wr_acc) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          os8_sel,
  input  logic          fifo_on,
  input  logic [CW-1:0] trig_lvl,
  input  logic          irq_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          isr_rd,
  output logic          txd,
  output logic          hold_empty,
  output logic          shift_empty,
  output logic          txe_pend,
  output logic          irq
);
  logic [DW-1:0] q_dout;
  logic [CW-1:0] level;
  logic          wr_acc;
  logic          load;
  logic          frame_done;
  logic          below;
  logic          pend_set;

  txq_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) fifo_i (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .push(wr_en), .din(wr_data),
    .pop(load), .dout(q_dout), .level(level), .accept(wr_acc)
  );

  txq_shifter #(.DW(DW)) shift_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .os8(os8_sel),
    .have_data(!hold_empty), .din(q_dout), .pop(load), .txd(txd),
    .idle(shift_empty), .frame_done(frame_done)
  );

  assign hold_empty = (level == '0);
  assign below      = txq_pkg::below_trig(32'(level), 32'(trig_lvl), fifo_on);

  txq_irq irq_i (
    .clk(clk), .rst_n(rst_n), .below(below), .isr_rd(isr_rd), .wr_acc(wr_acc),
    .irq_en(irq_en), .pend(txe_pend), .pend_set(pend_set), .irq(irq)
  );
endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          fifo_on,
  input logic          wr_en,
  input logic          isr_rd,
  input logic          txd,
  input logic          hold_empty,
  input logic          shift_empty,
  input logic          txe_pend,
  input logic [CW-1:0] level,
  input logic          wr_acc,
  input logic          load,
  input logic          frame_done,
  input logic          pend_set
);
  // R1
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_acc && !load) |=> $stable(level));

  // R2
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && $stable(fifo_on)) |-> level <= CW'(1));

  // R3
  hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !hold_empty);

  // R4
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && hold_empty) |=> shift_empty);

  // R5
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_empty) |-> !txd);

  // R7
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (tick && !hold_empty));

  // R7
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_empty && !hold_empty && tick) |=> !shift_empty);

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set |=> txe_pend);

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !pend_set) |=> !txe_pend);
endmodule

bind serial_tx_engine txq_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .fifo_on(fifo_on), .wr_en(wr_en),
  .isr_rd(isr_rd), .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty),
  .txe_pend(txe_pend), .level(level), .wr_acc(wr_acc), .load(load),
  .frame_done(frame_done), .pend_set(pend_set)
);

// File: tb/serial_tx_engine_tb_top.sv
`timescale 1ns/1ps
module serial_tx_engine_tb_top;
  localparam int TP = 4;        // clocks between tick pulses
  localparam int WD = 190000;   // watchdog limit in clocks
  localparam int NV = 4;
  // fields: [23] fifo_on, [22] os8, [21:15] trigger, [14:8] byte count, [7:0] seed
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 1'b1, 7'd8,  7'd64, 8'h11},
    {1'b1, 1'b0, 7'd4,  7'd20, 8'h5A},
    {1'b1, 1'b0, 7'd16, 7'd10, 8'hC3},
    {1'b1, 1'b1, 7'd0,  7'd6,  8'h80}
  };

  logic clk = 0, rst_n = 0, tick = 0;
  logic os8_sel = 0, fifo_on = 1, irq_en = 0, wr_en = 0, isr_rd = 0;
  logic [6:0] trig_lvl = 0;
  logic [7:0] wr_data = 0;
  logic txd, hold_empty, shift_empty, txe_pend, irq;

  int nchk = 0, nerr = 0;
  int tdiv = 0;
  int bitclk = 64;
  logic [7:0] rx_buf [0:1023];
  int rx_n = 0, rx_ferr = 0, rx_join = 0, irq_rise = 0;
  logic irq_q = 0;
  logic [7:0] rxb;

  always #2 clk = ~clk;

  serial_tx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .os8_sel(os8_sel), .fifo_on(fifo_on),
    .trig_lvl(trig_lvl), .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
    .isr_rd(isr_rd), .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty),
    .txe_pend(txe_pend), .irq(irq)
  );

  always @(negedge clk) begin
    tick <= (tdiv == TP - 1);
    tdiv <= (tdiv == TP - 1) ? 0 : tdiv + 1;
    irq_q <= irq;
    if (irq === 1'b1 && irq_q !== 1'b1) irq_rise <= irq_rise + 1;
  end

  // Line decoder: bit period in clocks is bitclk = TP * ticks per bit.
  initial begin
    forever begin
      @(negedge clk);
      while (rst_n === 1'b1 && txd === 1'b0) begin
        repeat (bitclk / 2) @(negedge clk);
        if (txd !== 1'b0) rx_ferr++;
        for (int k = 0; k < 8; k++) begin
          repeat (bitclk) @(negedge clk);
          rxb[k] = txd;
        end
        repeat (bitclk) @(negedge clk);
        if (txd !== 1'b1) rx_ferr++;
        rx_buf[rx_n % 1024] = rxb;
        rx_n++;
        repeat (bitclk / 2) @(negedge clk);
        if (txd === 1'b0) rx_join++;
      end
    end
  end

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 29);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic do_reset(input logic fm, input logic o8, input int trg, input logic en);
    @(negedge clk);
    rst_n = 0; wr_en = 0; isr_rd = 0;
    fifo_on = fm; os8_sel = o8; trig_lvl = 7'(trg); irq_en = en;
    bitclk = TP * (o8 ? 8 : 16);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic burst(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1; wr_data = pat(seed, i);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle;
    repeat (8) @(negedge clk);
    while (!(hold_empty && shift_empty)) @(negedge clk);
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic chk_data(input string req, input int base, input int n, input logic [7:0] seed);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (rx_buf[(base + i) % 1024] !== pat(seed, i)) bad++;
    chk(req, bad, 0);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog all requirements actual=%0d expected=done", WD);
    summary();
    $finish;
  end

  initial begin
    int b0, f0, j0, i0, wt;
    // R11 reset state
    do_reset(1, 0, 4, 1);
    chk("R11 txd idle", txd, 1);
    chk("R11 hold_empty", hold_empty, 1);
    chk("R11 shift_empty", shift_empty, 1);
    chk("R11 txe_pend", txe_pend, 0);
    chk("R11 irq", irq, 0);

    // table of bursts: R1 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      logic fm, o8; int trg, n; logic [7:0] sd;
      fm = VEC[v][23]; o8 = VEC[v][22]; trg = int'(VEC[v][21:15]);
      n = int'(VEC[v][14:8]); sd = VEC[v][7:0];
      do_reset(fm, o8, trg, 1);
      b0 = rx_n; f0 = rx_ferr; j0 = rx_join; i0 = irq_rise;
      burst(n, sd);
      wait_idle();
      chk("R5 R6 frame count", rx_n - b0, n);
      chk("R5 R6 framing errors", rx_ferr - f0, 0);
      chk_data("R1 R5 data order", b0, n, sd);
      chk("R7 back-to-back joins", rx_join - j0, n - 1);
      chk("R8 event count", irq_rise - i0, (trg != 0 && n - 1 >= trg) ? 1 : 0);
    end

    // R1 overflow: 70 writes, one pop during the burst, so 65 kept
    do_reset(1, 1, 0, 0);
    b0 = rx_n;
    burst(70, 8'h3C);
    chk("R3 hold_empty after writes", hold_empty, 0);
    wait_idle();
    chk("R1 accepted bytes", rx_n - b0, 65);
    chk_data("R1 kept bytes order", b0, 65, 8'h3C);

    // R9 R10 R8 R4: event latched with interrupt disabled
    do_reset(1, 1, 3, 0);
    b0 = rx_n;
    burst(6, 8'h47);
    while (!hold_empty) @(negedge clk);
    chk("R9 irq gated off", irq, 0);
    chk("R8 pending latched", txe_pend, 1);
    chk("R4 shifter busy while holding empty", shift_empty, 0);
    irq_en = 1;
    @(negedge clk);
    chk("R9 irq after enable", irq, 1);
    isr_rd = 1;
    @(negedge clk);
    isr_rd = 0;
    chk("R10 read clears irq", irq, 0);
    chk("R10 read clears pending", txe_pend, 0);
    wait_idle();
    chk("R4 line idle high", txd, 1);
    chk("R1 six bytes sent", rx_n - b0, 6);

    // R10 write clear, R8 re-arm
    do_reset(1, 1, 3, 1);
    b0 = rx_n;
    burst(5, 8'h92);
    wt = 0;
    while (irq !== 1'b1 && wt < 5000) begin @(negedge clk); wt++; end
    chk("R8 first event", irq, 1);
    wr_en = 1; wr_data = 8'hE7;
    @(negedge clk);
    wr_en = 0;
    chk("R10 write clears irq", irq, 0);
    wt = 0;
    while (irq !== 1'b1 && wt < 5000) begin @(negedge clk); wt++; end
    chk("R8 event re-armed", irq, 1);
    wait_idle();
    chk("R8 R10 bytes sent", rx_n - b0, 6);
    chk("R10 appended byte", rx_buf[(b0 + 5) % 1024], 8'hE7);

    // R2 single holding byte, trigger ignored
    do_reset(0, 0, 40, 1);
    b0 = rx_n; i0 = irq_rise;
    burst(2, 8'h33);
    wait_idle();
    chk("R2 second write dropped", rx_n - b0, 1);
    chk("R2 held byte", rx_buf[b0 % 1024], pat(8'h33, 0));
    chk("R2 event on handover", irq_rise - i0, 1);
    @(negedge clk);
    wr_en = 1; wr_data = 8'hA5;
    @(negedge clk);
    wr_en = 0;
    chk("R10 write clears irq single mode", irq, 0);
    wait_idle();
    chk("R2 second handover event", irq_rise - i0, 2);
    chk("R2 second byte", rx_buf[(b0 + 1) % 1024], 8'hA5);

    // R11 reset during a frame
    do_reset(1, 0, 2, 1);
    burst(3, 8'h01);
    repeat (100) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R11 txd in reset", txd, 1);
    chk("R11 hold_empty in reset", hold_empty, 1);
    chk("R11 shift_empty in reset", shift_empty, 1);
    chk("R11 irq in reset", irq, 0);

    summary();
    $finish;
  end
endmodule